// File: doc/BRIEF.md
# Serial Configuration Word Loader

This block accepts a long configuration word over a three-wire serial port made up of a data line, a shift clock and a load strobe. It samples all three pins in its own system clock domain. A data bit is taken in on each rising edge of the shift clock and enters a staging shift register at the least significant end. The first bit sent therefore ends up in the most significant position once the whole word has been shifted in. The load strobe is level sensitive. While it is high, a holding register copies the staging register on every cycle. A strobe pulse after a complete shift moves the whole word across at once. Shifting while the strobe is held high passes each new bit straight through to the live configuration.

The held word drives the rest of the device, together with a flag that marks whether any load has happened since reset. Out of reset the held word carries a parameterised default, which by convention selects plain reference pass-through on every output. Downstream logic is expected to treat the word as the default until the flag is set. Field meanings beyond bit positions are left to the consumers.

Top module: `serial_cfg_loader`

## Requirements
- R1: After reset, `cfg_word` equals the default word (all zeros with default parameters) and `cfg_programmed` is 0; `cfg_word` equals the default whenever `cfg_programmed` is 0.
- R2: Bits are shifted in most significant first: after WORD_W shift-clock rising edges and a strobe pulse, `cfg_word[WORD_W-1]` holds the first bit sent and `cfg_word[0]` the last.
- R3: While `ser_strobe` is low, shift-clock activity leaves `cfg_word` unchanged.
- R4: A rising edge on `ser_strobe` copies the staged word into `cfg_word` and sets `cfg_programmed` to 1.
- R5: Once set, `cfg_programmed` stays 1 until reset, through any further strobes or shifts.
- R6: While `ser_strobe` is high, every shift-clock rising edge updates `cfg_word` with the new staged word within four system clock cycles of the pin edge.
- R7: Asserting `rst_n` low after a load returns `cfg_word` to the default and clears `cfg_programmed`.
- R8: Changes on `ser_data` with no shift-clock rising edge do not alter the staged word, so `cfg_word` stays unchanged even while `ser_strobe` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ser_data | input | 1 | Serial data bit, sampled on the shift clock's rising edge |
| ser_clk | input | 1 | Serial shift clock |
| ser_strobe | input | 1 | Level-sensitive load strobe; high makes the holding register follow the staging register |
| cfg_word | output | WORD_W (160) | Held configuration word |
| cfg_programmed | output | 1 | Set by the first strobe after reset |

## Verification
The assertions assume that the serial pins move slowly compared with the system clock. Each pin level must last at least two system cycles so that it can be captured. Data must be steady across the synchronised shift-clock edge, which holds because data and shift clock pass through synchroniser chains of equal depth. The bench keeps to these conditions by changing pins only on falling system-clock edges. It changes data two cycles before a shift-clock rise and holds every shift-clock and strobe phase for at least four cycles. Within those limits it sends several computed 160-bit patterns with the strobe low and with the strobe high, and it toggles data with no shift-clock edge to confirm that nothing moves.

// File: rtl/cfgload_pkg.sv
package cfgload_pkg;
  localparam int unsigned CFG_WORD_W_DEF = 160;
  localparam int unsigned SYNC_DEPTH_DEF = 2;

  typedef struct packed {
    logic data;
    logic sclk;
    logic strobe;
  } ser_pins_t;

  localparam int unsigned SER_PINS_W = $bits(ser_pins_t);
endpackage

// File: rtl/cfgload_rst_sync.sv
module cfgload_rst_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [DEPTH-1:0] chain_q;
  logic [DEPTH-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[DEPTH-1];
endmodule

// File: rtl/cfgload_sync.sv
module cfgload_sync #(
  parameter int unsigned WIDTH = 3,
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [DEPTH];
  logic [WIDTH-1:0] stage_d [DEPTH];

  always_comb begin
    stage_d[0] = async_in;
    for (int s = 1; s < DEPTH; s++) stage_d[s] = stage_q[s-1];
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_d[g];
      end
    end
  endgenerate

  assign sync_out = stage_q[DEPTH-1];
endmodule

// File: rtl/cfgload_shift.sv
module cfgload_shift #(
  parameter int unsigned WORD_W = 160
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              data_s,
  output logic [WORD_W-1:0] stage
);
  logic              sclk_prev_q;
  logic              shift_en;
  logic [WORD_W-1:0] stage_q;
  logic [WORD_W-1:0] stage_d;

  always_comb begin
    shift_en = sclk_s & ~sclk_prev_q;
    stage_d  = stage_q;
    if (shift_en) stage_d = {stage_q[WORD_W-2:0], data_s};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q <= 1'b0;
      stage_q     <= '0;
    end else begin
      sclk_prev_q <= sclk_s;
      stage_q     <= stage_d;
    end
  end

  assign stage = stage_q;

  p_no_edge_no_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(sclk_s && !sclk_prev_q) |=> $stable(stage_q));

  p_msb_first_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_s && !sclk_prev_q) |=> (stage_q[0] == $past(data_s)));
endmodule

// File: rtl/cfgload_hold.sv
module cfgload_hold #(
  parameter int unsigned       WORD_W     = 160,
  parameter logic [WORD_W-1:0] RESET_WORD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_s,
  input  logic [WORD_W-1:0] stage,
  output logic [WORD_W-1:0] hold,
  output logic              programmed
);
  logic              strobe_prev_q;
  logic              strobe_rise;
  logic [WORD_W-1:0] hold_q;
  logic [WORD_W-1:0] hold_d;
  logic              prog_q;
  logic              prog_d;

  always_comb begin
    strobe_rise = strobe_s & ~strobe_prev_q;
    hold_d      = strobe_s ? stage : hold_q;
    prog_d      = prog_q | strobe_rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_prev_q <= 1'b0;
      hold_q        <= RESET_WORD;
      prog_q        <= 1'b0;
    end else begin
      strobe_prev_q <= strobe_s;
      hold_q        <= hold_d;
      prog_q        <= prog_d;
    end
  end

  assign hold       = hold_q;
  assign programmed = prog_q;

  p_hold_when_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_s |=> $stable(hold_q));

  p_follow_when_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_s |=> (hold_q == $past(stage)));

  p_prog_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    prog_q |=> prog_q);

  p_prog_needs_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_q) |-> $past(strobe_s));
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import cfgload_pkg::*;
#(
  parameter int unsigned       WORD_W     = CFG_WORD_W_DEF,
  parameter int unsigned       SYNC_DEPTH = SYNC_DEPTH_DEF,
  parameter logic [WORD_W-1:0] RESET_WORD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_data,
  input  logic              ser_clk,
  input  logic              ser_strobe,
  output logic [WORD_W-1:0] cfg_word,
  output logic              cfg_programmed
);
  logic              rst_int_n;
  ser_pins_t         pins_raw;
  ser_pins_t         pins_s;
  logic [WORD_W-1:0] stage;

  assign pins_raw = '{data: ser_data, sclk: ser_clk, strobe: ser_strobe};

  cfgload_rst_sync #(.DEPTH(SYNC_DEPTH)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  cfgload_sync #(.WIDTH(SER_PINS_W), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .async_in (pins_raw),
    .sync_out (pins_s)
  );

  cfgload_shift #(.WORD_W(WORD_W)) u_shift (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .sclk_s (pins_s.sclk),
    .data_s (pins_s.data),
    .stage  (stage)
  );

  cfgload_hold #(.WORD_W(WORD_W), .RESET_WORD(RESET_WORD)) u_hold (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .strobe_s   (pins_s.strobe),
    .stage      (stage),
    .hold       (cfg_word),
    .programmed (cfg_programmed)
  );

  p_default_until_loaded_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    !cfg_programmed |-> (cfg_word == RESET_WORD));
endmodule

// File: tb/test_serial_cfg_loader.sv
module test_serial_cfg_loader;
  localparam int unsigned W      = 160;
  localparam time         CLK_PER = 10ns;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         ser_data, ser_clk, ser_strobe;
  logic [W-1:0] cfg_word;
  logic         cfg_programmed;

  logic [W-1:0] exp_stage;
  logic [W-1:0] exp_hold;
  int           n_checks = 0;
  int           n_fail   = 0;
  bit           finished = 0;

  always #(CLK_PER/2) clk = ~clk;

  serial_cfg_loader i_serial_cfg_loader (
    .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk),
    .ser_strobe(ser_strobe), .cfg_word(cfg_word), .cfg_programmed(cfg_programmed)
  );

  function automatic bit pat(int sel, int i);
    case (sel)
      0:       return ((i * 37 + 11) % 7) < 3;
      1:       return i[0];
      default: return ((i / 3) % 2) == 1;
    endcase
  endfunction

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_word(string req, logic [W-1:0] exp);
    n_checks++;
    if (cfg_word !== exp) begin
      n_fail++;
      $display("FAIL %s cfg_word actual=%h expected=%h", req, cfg_word, exp);
    end
  endtask

  task automatic chk_bit(string req, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic shift_bit(bit b);
    ser_data = b;
    wait_n(2);
    ser_clk = 1'b1;
    wait_n(4);
    ser_clk = 1'b0;
    wait_n(4);
    exp_stage = {exp_stage[W-2:0], b};
  endtask

  task automatic pulse_strobe();
    ser_strobe = 1'b1;
    wait_n(6);
    ser_strobe = 1'b0;
    wait_n(6);
    exp_hold = exp_stage;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(4);
    exp_stage = '0;
    exp_hold  = '0;
  endtask

  initial begin
    ser_data = 0; ser_clk = 0; ser_strobe = 0;
    do_reset();
    // R1: reset state
    chk_word("R1", '0);
    chk_bit("R1 programmed", cfg_programmed, 1'b0);

    // R3: strobe low shifting leaves the word alone
    for (int i = 0; i < W; i++) begin
      shift_bit(pat(0, i));
      chk_word("R3", exp_hold);
    end
    chk_bit("R1 programmed before strobe", cfg_programmed, 1'b0);

    // R4 / R2: strobe transfers the staged word, first bit at MSB
    pulse_strobe();
    chk_word("R4", exp_hold);
    chk_bit("R4 programmed", cfg_programmed, 1'b1);
    chk_bit("R2 msb", cfg_word[W-1], pat(0, 0));
    chk_bit("R2 lsb", cfg_word[0], pat(0, W-1));

    // R3 again with a second pattern, then R5 on a second strobe
    for (int i = 0; i < W; i++) begin
      shift_bit(pat(1, i));
      chk_word("R3 second pattern", exp_hold);
      chk_bit("R5 sticky", cfg_programmed, 1'b1);
    end
    pulse_strobe();
    chk_word("R4 second load", exp_hold);
    chk_bit("R2 msb second", cfg_word[W-1], pat(1, 0));
    chk_bit("R5 after second strobe", cfg_programmed, 1'b1);

    // R6: strobe held high, each bit passes straight through
    ser_strobe = 1'b1;
    wait_n(4);
    chk_word("R6 enter transparent", exp_stage);
    for (int i = 0; i < W; i++) begin
      shift_bit(pat(2, i));
      chk_word("R6", exp_stage);
    end

    // R8: data toggles without a shift edge, strobe still high
    for (int k = 0; k < 10; k++) begin
      ser_data = ~ser_data;
      wait_n(3);
    end
    chk_word("R8 sclk low", exp_stage);
    ser_clk = 1'b1;
    wait_n(4);
    exp_stage = {exp_stage[W-2:0], ser_data};
    chk_word("R6 extra edge", exp_stage);
    for (int k = 0; k < 10; k++) begin
      ser_data = ~ser_data;
      wait_n(3);
    end
    chk_word("R8 sclk high", exp_stage);
    ser_clk = 1'b0;
    wait_n(4);
    ser_strobe = 1'b0;
    wait_n(4);
    exp_hold = exp_stage;
    chk_word("R3 after strobe release", exp_hold);

    // R7: reset after load returns to default
    do_reset();
    chk_word("R7", '0);
    chk_bit("R7 programmed", cfg_programmed, 1'b0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule